// File: doc/BRIEF.md
# Single/Dual-Slope PWM Timer

This block is a compare-based pulse-width modulator built around a 16-bit up/down counter. A shared period value sets the top of the count range, and therefore the resolution and the output period. Each of the four compare channels holds its own threshold, which sets the duty cycle of that channel's waveform pin. A programmable divider turns the peripheral clock into count steps, so slow outputs can be produced without widening the counter.

Two counting shapes are available. In single-slope operation the counter climbs from zero to the period value and then restarts at zero, which gives edge-aligned pulses. In dual-slope operation it climbs to the period value, holds there for one step, and then descends back to zero, which gives centre-aligned pulses. In both shapes, period and compare writes first land in shadow registers and are copied into the working registers at a well-defined point in the cycle, so a running waveform never sees a half-applied setting. While the timer is disabled, the shadow values pass straight through, the counter rests at zero and every pin is driven low.

Top module: `slope_pwm_timer`

## Requirements
- R1: While `enable` is low (including straight after reset) every `waveOut` bit is 0, `updEvt` and `matchEvt` stay 0, the counter rests at zero, and period and compare writes reach the working registers without waiting for an update.
- R2: In single-slope mode (`dualMode`=0) the counter steps 0, 1, ..., PER and back to 0, so one `updEvt` pulse arrives every N*(PER+1) clocks and the count never exceeds PER.
- R3: In single-slope mode a channel with 1 <= CMP <= PER is high for N*CMP clocks of each period (high from zero, low from the step where the count equals CMP).
- R4: In dual-slope mode (`dualMode`=1) the counter rises from 0 to PER, falls back to 0, and holds each end for one step, so one `updEvt` pulse (at the bottom) arrives every 2*N*PER clocks.
- R5: In dual-slope mode a channel with 1 <= CMP < PER is set at the bottom, cleared at the rising-count match and set again at the falling-count match, giving N*2*CMP high clocks per period.
- R6: In either mode, CMP = 0 keeps the channel low for the whole period and CMP > PER keeps it high for the whole period.
- R7: `preSel` picks the divide factor N: code 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8, 4 gives 64, 5 gives 256, and 6 or 7 give 1024.
- R8: A period write below 3 is stored as 3, so the working period is never below 3 (2-bit minimum resolution).
- R9: While enabled, period and compare writes take effect only at the next update event (the wrap from PER to 0 in single-slope mode, the departure from the bottom in dual-slope mode); the period in progress keeps its old settings.
- R10: `matchEvt[i]` gives one one-clock pulse for each count step whose value equals that channel's CMP: once per period in single-slope mode for CMP <= PER, twice per period in dual-slope mode for 1 <= CMP < PER, once for CMP = 0 in dual-slope mode, and never for CMP > PER.
- R11: `updEvt` is a single-clock pulse and is never high on two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the counter when high; holds it at zero and drives pins low when low |
| dualMode | input | 1 | 0 selects single-slope counting, 1 selects dual-slope counting |
| preSel | input | 3 | Clock divide factor select (see R7) |
| perWrEn | input | 1 | Writes `perWrData` into the period shadow register |
| perWrData | input | W (16) | Period value to write (clamped to at least 3) |
| cmpWrEn | input | CH (4) | One bit per channel; writes `cmpWrData` into that channel's compare shadow |
| cmpWrData | input | W (16) | Compare value to write |
| waveOut | output | CH (4) | PWM waveform, one bit per channel |
| matchEvt | output | CH (4) | One-clock pulse per count step equal to the channel's compare value |
| updEvt | output | 1 | One-clock pulse when shadow values are copied into the working registers |

## Verification
The assertions take for granted that the reset is applied before anything else and that `enable`, `dualMode`, `preSel` and the write ports are driven synchronously with known values once reset is released; given that, the disabled-state, pulse-width, range and period-floor properties must hold under any mix of writes and mode changes. The stimulus keeps inside this by changing inputs only on the falling clock edge, and by changing mode, divide factor and settings with the timer disabled, plus one extra idle clock before re-enabling so that the pass-through of shadow values has settled. Buffered-write behaviour is exercised separately with writes issued during a running period, where the old settings must persist until the next update pulse.

// File: rtl/slope_pwm_pkg.sv
package slope_pwm_pkg;

  // Strobes passed from the count control to the datapath once per clock.
  typedef struct packed {
    logic tick;     // counter takes a step on this clock edge
    logic upd;      // shadow registers copy to working registers on this edge
    logic countUp;  // current counting direction (always 1 in single-slope)
  } stepStrb_t;

  // Log2 of the divide factor selected by the 3-bit code.
  function automatic int unsigned preShift(input logic [2:0] sel);
    int unsigned s;
    case (sel)
      3'd0:    s = 0;
      3'd1:    s = 1;
      3'd2:    s = 2;
      3'd3:    s = 3;
      3'd4:    s = 6;
      3'd5:    s = 8;
      default: s = 10;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/slope_pwm_ctrl.sv
module slope_pwm_ctrl
  import slope_pwm_pkg::*;
#(
  parameter int W     = 16,
  parameter int PRE_W = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          dualMode,
  input  logic [2:0]    preSel,
  input  logic [W-1:0]  perAct,
  output stepStrb_t     strb,
  output logic [W-1:0]  cnt
);

  localparam int PW1 = PRE_W + 1;

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preMask;
  logic [PW1-1:0]   preFull;
  int unsigned      preSh;
  logic             tick;

  logic             countUp;
  logic [W-1:0]     cntNext;
  logic             upNext;
  logic             updNow;

  // Divider: free-running while enabled, cleared while disabled.
  always_ff @(posedge clk) begin
    if (!rst_n || !enable) preCnt <= '0;
    else                   preCnt <= preCnt + PRE_W'(1);
  end

  always_comb begin
    preSh = preShift(preSel);
    if (preSh > PRE_W) preSh = PRE_W;
    preFull = (PW1'(1) << preSh) - PW1'(1);
    preMask = preFull[PRE_W-1:0];
  end

  assign tick = enable && ((preCnt & preMask) == preMask);

  // Next counter value and direction.
  always_comb begin
    cntNext = cnt;
    upNext  = dualMode ? countUp : 1'b1;
    updNow  = 1'b0;
    if (tick) begin
      if (!dualMode) begin
        upNext = 1'b1;
        if (cnt >= perAct) begin
          cntNext = '0;
          updNow  = 1'b1;
        end else begin
          cntNext = cnt + W'(1);
        end
      end else begin
        updNow = (cnt == '0);
        if (countUp) begin
          if (cnt >= perAct) begin
            cntNext = cnt - W'(1);
            upNext  = 1'b0;
          end else begin
            cntNext = cnt + W'(1);
          end
        end else begin
          if (cnt == '0) begin
            cntNext = W'(1);
            upNext  = 1'b1;
          end else begin
            cntNext = cnt - W'(1);
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      cnt     <= '0;
      countUp <= 1'b1;
    end else begin
      cnt     <= cntNext;
      countUp <= upNext;
    end
  end

  always_comb begin
    strb.tick    = tick;
    strb.upd     = updNow;
    strb.countUp = countUp;
  end

endmodule

// File: rtl/slope_pwm_datapath.sv
module slope_pwm_datapath
  import slope_pwm_pkg::*;
#(
  parameter int W       = 16,
  parameter int CH      = 4,
  parameter int MIN_PER = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  stepStrb_t     strb,
  input  logic [W-1:0]  cnt,
  input  logic          perWrEn,
  input  logic [W-1:0]  perWrData,
  input  logic [CH-1:0] cmpWrEn,
  input  logic [W-1:0]  cmpWrData,
  output logic [W-1:0]  perAct,
  output logic [CH-1:0] waveOut,
  output logic [CH-1:0] matchEvt,
  output logic          updEvt
);

  localparam logic [W-1:0] PER_FLOOR = W'(MIN_PER);
  localparam logic [W-1:0] PER_RESET = '1;

  logic [W-1:0] perBuf;
  logic         loadAct;

  // Working registers follow the shadows while stopped, else at update.
  assign loadAct = !enable || strb.upd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      perBuf <= PER_RESET;
    end else if (perWrEn) begin
      perBuf <= (perWrData < PER_FLOOR) ? PER_FLOOR : perWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       perAct <= PER_RESET;
    else if (loadAct) perAct <= perBuf;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) updEvt <= 1'b0;
    else        updEvt <= strb.upd;
  end

  for (genvar i = 0; i < CH; i++) begin : g_chan
    logic [W-1:0] cmpBuf;
    logic [W-1:0] cmpAct;
    logic         level;

    always_ff @(posedge clk) begin
      if (!rst_n)          cmpBuf <= '0;
      else if (cmpWrEn[i]) cmpBuf <= cmpWrData;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)       cmpAct <= '0;
      else if (loadAct) cmpAct <= cmpBuf;
    end

    // High below the threshold on the way up, at or below it on the way down.
    always_comb begin
      if (cmpAct == '0)      level = 1'b0;
      else if (strb.countUp) level = (cnt < cmpAct);
      else                   level = (cnt <= cmpAct);
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        waveOut[i]  <= 1'b0;
        matchEvt[i] <= 1'b0;
      end else begin
        waveOut[i]  <= enable && level;
        matchEvt[i] <= strb.tick && (cnt == cmpAct);
      end
    end
  end

endmodule

// File: rtl/slope_pwm_timer.sv
module slope_pwm_timer
  import slope_pwm_pkg::*;
#(
  parameter int W       = 16,
  parameter int CH      = 4,
  parameter int PRE_W   = 10,
  parameter int MIN_PER = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          dualMode,
  input  logic [2:0]    preSel,
  input  logic          perWrEn,
  input  logic [W-1:0]  perWrData,
  input  logic [CH-1:0] cmpWrEn,
  input  logic [W-1:0]  cmpWrData,
  output logic [CH-1:0] waveOut,
  output logic [CH-1:0] matchEvt,
  output logic          updEvt
);

  stepStrb_t    strb;
  logic [W-1:0] cnt;
  logic [W-1:0] perAct;

  slope_pwm_ctrl #(.W(W), .PRE_W(PRE_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .dualMode (dualMode),
    .preSel   (preSel),
    .perAct   (perAct),
    .strb     (strb),
    .cnt      (cnt)
  );

  slope_pwm_datapath #(.W(W), .CH(CH), .MIN_PER(MIN_PER)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .strb      (strb),
    .cnt       (cnt),
    .perWrEn   (perWrEn),
    .perWrData (perWrData),
    .cmpWrEn   (cmpWrEn),
    .cmpWrData (cmpWrData),
    .perAct    (perAct),
    .waveOut   (waveOut),
    .matchEvt  (matchEvt),
    .updEvt    (updEvt)
  );

endmodule

// File: rtl/slope_pwm_checker.sv
module slope_pwm_checker #(
  parameter int W       = 16,
  parameter int CH      = 4,
  parameter int MIN_PER = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic [CH-1:0] waveOut,
  input logic [CH-1:0] matchEvt,
  input logic          updEvt,
  input logic [W-1:0]  cnt,
  input logic [W-1:0]  perAct
);

  // R1
  disabled_wave_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (waveOut == '0));

  // R1
  disabled_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!updEvt && (matchEvt == '0)));

  // R11
  update_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    updEvt |=> !updEvt);

  // R2
  count_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= perAct);

  // R8
  period_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    perAct >= W'(MIN_PER));

endmodule

bind slope_pwm_timer slope_pwm_checker #(.W(W), .CH(CH), .MIN_PER(MIN_PER)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .enable   (enable),
  .waveOut  (waveOut),
  .matchEvt (matchEvt),
  .updEvt   (updEvt),
  .cnt      (cnt),
  .perAct   (perAct)
);

// File: tb/slope_pwm_timer_bench.sv
module slope_pwm_timer_bench;

  localparam int W  = 16;
  localparam int CH = 4;
  localparam int MAX_CYC = 190000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enable = 1'b0;
  logic          dualMode = 1'b0;
  logic [2:0]    preSel = 3'd0;
  logic          perWrEn = 1'b0;
  logic [W-1:0]  perWrData = '0;
  logic [CH-1:0] cmpWrEn = '0;
  logic [W-1:0]  cmpWrData = '0;
  logic [CH-1:0] waveOut;
  logic [CH-1:0] matchEvt;
  logic          updEvt;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  int mPer;
  int mHi [CH];
  int mMt [CH];

  always #10 clk = ~clk;

  slope_pwm_timer u_slope_pwm_timer (
    .clk(clk), .rst_n(rst_n), .enable(enable), .dualMode(dualMode),
    .preSel(preSel), .perWrEn(perWrEn), .perWrData(perWrData),
    .cmpWrEn(cmpWrEn), .cmpWrData(cmpWrData), .waveOut(waveOut),
    .matchEvt(matchEvt), .updEvt(updEvt)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic writePer(input logic [W-1:0] v);
    @(negedge clk);
    perWrEn = 1'b1; perWrData = v;
    @(negedge clk);
    perWrEn = 1'b0;
  endtask

  task automatic writeCmp(input int ch, input logic [W-1:0] v);
    @(negedge clk);
    cmpWrEn = '0; cmpWrEn[ch] = 1'b1; cmpWrData = v;
    @(negedge clk);
    cmpWrEn = '0;
  endtask

  // Stop, program, idle one clock, restart.
  task automatic setup(input bit dual, input logic [2:0] sel, input logic [W-1:0] per,
                       input logic [W-1:0] c0, input logic [W-1:0] c1,
                       input logic [W-1:0] c2, input logic [W-1:0] c3);
    @(negedge clk);
    enable = 1'b0; dualMode = dual; preSel = sel;
    writePer(per);
    writeCmp(0, c0); writeCmp(1, c1); writeCmp(2, c2); writeCmp(3, c3);
    @(negedge clk);
    @(negedge clk);
    enable = 1'b1;
  endtask

  // Count one period between update pulses, sampling at falling edges.
  task automatic measure(input bit synced);
    if (!synced) begin
      @(negedge clk);
      while (!updEvt) @(negedge clk);
    end
    mPer = 0;
    for (int i = 0; i < CH; i++) begin mHi[i] = 0; mMt[i] = 0; end
    do begin
      for (int i = 0; i < CH; i++) begin
        mHi[i] += int'(waveOut[i]);
        mMt[i] += int'(matchEvt[i]);
      end
      mPer++;
      @(negedge clk);
    end while (!updEvt);
  endtask

  task automatic testReset;
    @(negedge clk);
    check("R1", "reset waveOut", int'(waveOut), 0);
    check("R1", "reset updEvt", int'(updEvt), 0);
    check("R1", "reset matchEvt", int'(matchEvt), 0);
  endtask

  task automatic testSingle;
    setup(1'b0, 3'd0, 16'd9, 16'd0, 16'd3, 16'd9, 16'd12);
    measure(1'b0);
    measure(1'b1);
    check("R2", "single period", mPer, 10);
    check("R6", "single cmp0 high", mHi[0], 0);
    check("R3", "single cmp3 high", mHi[1], 3);
    check("R3", "single cmp=PER high", mHi[2], 9);
    check("R6", "single cmp>PER high", mHi[3], 10);
    check("R10", "single match cmp0", mMt[0], 1);
    check("R10", "single match cmp3", mMt[1], 1);
    check("R10", "single match cmp>PER", mMt[3], 0);
  endtask

  task automatic testDual;
    setup(1'b1, 3'd0, 16'd8, 16'd0, 16'd2, 16'd7, 16'd20);
    measure(1'b0);
    measure(1'b1);
    check("R4", "dual period", mPer, 16);
    check("R6", "dual cmp0 high", mHi[0], 0);
    check("R5", "dual cmp2 high", mHi[1], 4);
    check("R5", "dual cmp7 high", mHi[2], 14);
    check("R6", "dual cmp>PER high", mHi[3], 16);
    check("R10", "dual match cmp0", mMt[0], 1);
    check("R10", "dual match cmp2", mMt[1], 2);
    check("R10", "dual match cmp7", mMt[2], 2);
    check("R10", "dual match cmp>PER", mMt[3], 0);
  endtask

  task automatic testPrescale;
    setup(1'b1, 3'd1, 16'd5, 16'd0, 16'd2, 16'd0, 16'd0);
    measure(1'b0); measure(1'b1);
    check("R7", "div2 dual period", mPer, 20);
    check("R5", "div2 dual high", mHi[1], 8);
    setup(1'b0, 3'd2, 16'd4, 16'd0, 16'd2, 16'd0, 16'd0);
    measure(1'b0); measure(1'b1);
    check("R7", "div4 single period", mPer, 20);
    check("R3", "div4 single high", mHi[1], 8);
    setup(1'b0, 3'd3, 16'd3, 16'd0, 16'd0, 16'd0, 16'd0);
    measure(1'b0); measure(1'b1);
    check("R7", "div8 period", mPer, 32);
    setup(1'b0, 3'd4, 16'd4, 16'd0, 16'd2, 16'd0, 16'd0);
    measure(1'b0); measure(1'b1);
    check("R7", "div64 period", mPer, 320);
    check("R3", "div64 high", mHi[1], 128);
    setup(1'b0, 3'd5, 16'd3, 16'd0, 16'd0, 16'd0, 16'd0);
    measure(1'b0); measure(1'b1);
    check("R7", "div256 period", mPer, 1024);
    setup(1'b0, 3'd6, 16'd3, 16'd0, 16'd0, 16'd0, 16'd0);
    measure(1'b0); measure(1'b1);
    check("R7", "div1024 period", mPer, 4096);
    setup(1'b0, 3'd7, 16'd3, 16'd0, 16'd0, 16'd0, 16'd0);
    measure(1'b0); measure(1'b1);
    check("R7", "code7 period", mPer, 4096);
  endtask

  task automatic testClamp;
    setup(1'b0, 3'd0, 16'd1, 16'd0, 16'd0, 16'd0, 16'd0);
    measure(1'b0); measure(1'b1);
    check("R8", "single clamped period", mPer, 4);
    setup(1'b1, 3'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0);
    measure(1'b0); measure(1'b1);
    check("R8", "dual clamped period", mPer, 6);
  endtask

  // Writes during a running period wait for the next update.
  task automatic testBuffered;
    int hiOld;
    int perOld;
    setup(1'b0, 3'd0, 16'd9, 16'd0, 16'd3, 16'd0, 16'd0);
    measure(1'b0);
    perOld = 0; hiOld = 0;
    hiOld += int'(waveOut[1]); perOld++;
    perWrEn = 1'b1; perWrData = 16'd4;
    @(negedge clk);
    perWrEn = 1'b0;
    hiOld += int'(waveOut[1]); perOld++;
    cmpWrEn = 4'b0010; cmpWrData = 16'd1;
    @(negedge clk);
    cmpWrEn = '0;
    while (!updEvt) begin
      hiOld += int'(waveOut[1]); perOld++;
      @(negedge clk);
    end
    check("R9", "period in progress keeps old PER", perOld, 10);
    check("R9", "period in progress keeps old CMP", hiOld, 3);
    measure(1'b1);
    check("R9", "new PER after update", mPer, 5);
    check("R9", "new CMP after update", mHi[1], 1);
  endtask

  task automatic testDisable;
    int bad = 0;
    setup(1'b1, 3'd0, 16'd5, 16'd2, 16'd4, 16'd7, 16'd9);
    measure(1'b0);
    enable = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (waveOut != '0 || updEvt || matchEvt != '0) bad++;
    end
    check("R1", "activity while disabled", bad, 0);
  endtask

  initial begin
    repeat (MAX_CYC) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    testReset();
    testSingle();
    testDual();
    testClamp();
    testBuffered();
    testDisable();
    testPrescale();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule